// File: doc/BRIEF.md
# Nibble-wide accumulator CPU core

This block is a compact multi-cycle accumulator processor. It reads and writes a 256-word memory of 4-bit words through an 8-bit address bus and 4-bit data buses. Its architectural state is an 8-bit accumulator, an 8-bit program counter and three flags: carry (C), zero (Z) and an external data flag (D). An 8-bit operand register and a 4-bit opcode register are internal. Each instruction is one opcode word, and most are followed by two operand words. A state machine makes exactly one memory access per clock while it gathers the opcode, the operand nibbles and any memory data.

The memory sits outside the block. Writes happen on the clock edge while the write strobe is high. Reads are combinational: the word at the presented address must be on the read bus in the same cycle. A halt instruction parks the core until the restart input is seen high at a clock edge. An asynchronous external signal sets the sticky D flag through a synchroniser.

Top module: `nib_cpu`

## Requirements
- R1: Reset clears the PC, the accumulator and the C, Z and D flags. `halted` is low during and after reset, and the first fetch presents address 0.
- R2: Opcode values are 0 halt, 1 load, 2 store, 3 jump, 4 save-PC, 5 AND, 6 OR, 7 add, 8 subtract, 9 jump-if-Z-clear, A compare, B jump-if-D-clear, C jump-if-C-clear, D rotate-left, E rotate-right and F clear-flags. Opcodes 0, D, E and F occupy one word. All others are followed by two operand words, and the first of these holds bits 3:0 of the 8-bit operand.
- R3: Load and store treat the operand as an address. They move bits 3:0 at that address and bits 7:4 at address+1, and address+1 wraps from 0xFF to 0x00. Both leave the flags unchanged.
- R4: Add puts (AC + imm) mod 256 into AC. C is set to the carry out of bit 7, and Z is set when the result is zero.
- R5: Subtract puts (AC − imm) mod 256 into AC. C is set when AC < imm (borrow), and Z is set when the difference is zero. Compare sets C and Z in the same way and leaves AC unchanged.
- R6: AND and OR write AC bitwise with the immediate and set Z from the result. C is left unchanged.
- R7: Rotate-left shifts C into bit 0 and bit 7 into C. Rotate-right shifts C into bit 7 and bit 0 into C. Both leave Z unchanged.
- R8: Jump loads the PC with the operand. Each conditional jump does the same only when its flag (Z, D or C) is clear. Otherwise execution continues at the next instruction.
- R9: Save-PC writes the address of the following instruction (its own address + 3) to operand address and address+1, low nibble first.
- R10: After a halt, `halted` is high, no memory write occurs and the address bus shows the address after the halt word. A high `restart` at a clock edge resumes fetching at that address.
- R11: D is set once `data_flag_in` has passed a two-stage synchroniser. It stays set after the input falls, until clear-flags.
- R12: Clear-flags clears C, Z and D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Resume from the halted state |
| data_flag_in | input | 1 | Asynchronous external flag source for D |
| mem_addr | output | 8 | Memory word address |
| mem_rdata | input | 4 | Read data for `mem_addr`, same cycle |
| mem_wdata | output | 4 | Write data |
| mem_we | output | 1 | Write strobe, memory writes on the clock edge |
| halted | output | 1 | High while parked after a halt |

## Verification
Each arithmetic and logic opcode runs as a small program from vectors that hit the carry, the borrow and a zero result. The results reach the outside through a store and through conditional-jump probes that end on distinct halt addresses. A core that swapped operand nibbles, took carry as "no borrow", let AND/OR disturb C or let rotates touch Z would store a wrong byte or halt at the wrong address. Directed programs cover address wrap at 0xFF: a core missing it would overwrite address 0x100 mod nothing and leave word 0 intact. They also cover the return address saved by save-PC (off by three if taken from the opcode), the hold while halted followed by restart, D staying set after a short pulse, and D being cleared by clear-flags.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

    localparam int NIB_W  = 4;
    localparam int WORD_W = 2 * NIB_W;
    localparam int ADDR_W = WORD_W;

    typedef enum logic [NIB_W-1:0] {
        OP_HLT = 4'h0, OP_LDA = 4'h1, OP_STA = 4'h2, OP_JMP = 4'h3,
        OP_SPC = 4'h4, OP_AND = 4'h5, OP_OR  = 4'h6, OP_ADD = 4'h7,
        OP_SUB = 4'h8, OP_JNZ = 4'h9, OP_CMP = 4'hA, OP_JND = 4'hB,
        OP_JNC = 4'hC, OP_ROL = 4'hD, OP_ROR = 4'hE, OP_CLF = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_OPND_LO, ST_OPND_HI, ST_MEM_LO, ST_MEM_HI, ST_EXECUTE, ST_HALTED
    } state_e;

    typedef struct packed {
        state_e            st;
        op_e               ir;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ac;
        logic [ADDR_W-1:0] dar;
        logic              c;
        logic              z;
        logic              d;
    } core_t;

    function automatic logic is_single(op_e op);
        return (op == OP_HLT) || (op == OP_ROL) || (op == OP_ROR) || (op == OP_CLF);
    endfunction

    function automatic logic is_mem_op(op_e op);
        return (op == OP_LDA) || (op == OP_STA) || (op == OP_SPC);
    endfunction

endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], din};

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_cpu_pkg::*;
(
    input  op_e               op,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] opnd,
    input  logic              c_in,
    input  logic              z_in,
    output logic [WORD_W-1:0] res,
    output logic              c_out,
    output logic              z_out,
    output logic              wr_ac
);
    logic [WORD_W:0] sum, diff;

    always_comb begin
        sum   = {1'b0, ac} + {1'b0, opnd};
        diff  = {1'b0, ac} - {1'b0, opnd};
        res   = ac;
        c_out = c_in;
        z_out = z_in;
        wr_ac = 1'b0;
        unique case (op)
            OP_AND: begin res = ac & opnd; z_out = (res == '0); wr_ac = 1'b1; end
            OP_OR:  begin res = ac | opnd; z_out = (res == '0); wr_ac = 1'b1; end
            OP_ADD: begin
                res   = sum[WORD_W-1:0];
                c_out = sum[WORD_W];
                z_out = (res == '0);
                wr_ac = 1'b1;
            end
            OP_SUB, OP_CMP: begin
                res   = diff[WORD_W-1:0];
                c_out = diff[WORD_W];
                z_out = (res == '0);
                wr_ac = (op == OP_SUB);
            end
            OP_ROL: begin
                res   = {ac[WORD_W-2:0], c_in};
                c_out = ac[WORD_W-1];
                wr_ac = 1'b1;
            end
            OP_ROR: begin
                res   = {c_in, ac[WORD_W-1:1]};
                c_out = ac[0];
                wr_ac = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
    import nib_cpu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              data_flag_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              mem_we,
    output logic              halted
);
    localparam core_t RESET_VAL = '{st: ST_FETCH, ir: OP_HLT, pc: '0, ac: '0,
                                    dar: '0, c: 1'b0, z: 1'b0, d: 1'b0};

    core_t q, n;
    logic d_seen;
    logic [WORD_W-1:0] alu_res;
    logic alu_c, alu_z, alu_wr;
    logic [ADDR_W-1:0] dar_inc;

    nib_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(data_flag_in), .dout(d_seen)
    );

    nib_alu u_alu (
        .op(q.ir), .ac(q.ac), .opnd(q.dar), .c_in(q.c), .z_in(q.z),
        .res(alu_res), .c_out(alu_c), .z_out(alu_z), .wr_ac(alu_wr)
    );

    always_comb begin
        n         = q;
        dar_inc   = q.dar + ADDR_W'(1);
        mem_addr  = q.pc;
        mem_wdata = '0;
        mem_we    = 1'b0;
        if (d_seen) n.d = 1'b1;

        unique case (q.st)
            ST_FETCH: begin
                n.ir = op_e'(mem_rdata);
                n.pc = q.pc + ADDR_W'(1);
                n.st = is_single(op_e'(mem_rdata)) ? ST_EXECUTE : ST_OPND_LO;
            end
            ST_OPND_LO: begin
                n.dar[NIB_W-1:0] = mem_rdata;
                n.pc = q.pc + ADDR_W'(1);
                n.st = ST_OPND_HI;
            end
            ST_OPND_HI: begin
                n.dar[WORD_W-1:NIB_W] = mem_rdata;
                n.pc = q.pc + ADDR_W'(1);
                n.st = is_mem_op(q.ir) ? ST_MEM_LO : ST_EXECUTE;
            end
            ST_MEM_LO: begin
                mem_addr = q.dar;
                unique case (q.ir)
                    OP_LDA:  n.ac[NIB_W-1:0] = mem_rdata;
                    OP_STA:  begin mem_we = 1'b1; mem_wdata = q.ac[NIB_W-1:0]; end
                    OP_SPC:  begin mem_we = 1'b1; mem_wdata = q.pc[NIB_W-1:0]; end
                    default: ;
                endcase
                n.st = ST_MEM_HI;
            end
            ST_MEM_HI: begin
                mem_addr = dar_inc;
                unique case (q.ir)
                    OP_LDA:  n.ac[WORD_W-1:NIB_W] = mem_rdata;
                    OP_STA:  begin mem_we = 1'b1; mem_wdata = q.ac[WORD_W-1:NIB_W]; end
                    OP_SPC:  begin mem_we = 1'b1; mem_wdata = q.pc[WORD_W-1:NIB_W]; end
                    default: ;
                endcase
                n.st = ST_FETCH;
            end
            ST_EXECUTE: begin
                n.st = ST_FETCH;
                unique case (q.ir)
                    OP_HLT: n.st = ST_HALTED;
                    OP_JMP: n.pc = q.dar;
                    OP_JNZ: if (!q.z) n.pc = q.dar;
                    OP_JND: if (!q.d) n.pc = q.dar;
                    OP_JNC: if (!q.c) n.pc = q.dar;
                    OP_CLF: begin n.c = 1'b0; n.z = 1'b0; n.d = 1'b0; end
                    default: begin
                        if (alu_wr) n.ac = alu_res;
                        n.c = alu_c;
                        n.z = alu_z;
                    end
                endcase
            end
            ST_HALTED: if (restart) n.st = ST_FETCH;
            default: n.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= n;
    end

    assign halted = (q.st == ST_HALTED);

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH) |=> (q.pc == $past(q.pc) + ADDR_W'(1)));

    a_r3_pair_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MEM_LO) |=> (q.st == ST_MEM_HI && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    a_r4_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXECUTE && q.ir == OP_ADD)
        |=> ({q.c, q.ac} == {1'b0, $past(q.ac)} + {1'b0, $past(q.dar)}));

    a_r5_cmp_keeps_ac: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXECUTE && q.ir == OP_CMP) |=> $stable(q.ac));

    a_r9_write_source: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((q.st == ST_MEM_LO || q.st == ST_MEM_HI) &&
                    (q.ir == OP_STA || q.ir == OP_SPC)));

    a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !restart) |=> (halted && $stable(q.pc) && !mem_we));

    a_r11_d_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.d && !(q.st == ST_EXECUTE && q.ir == OP_CLF)) |=> q.d);

    a_r12_clf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXECUTE && q.ir == OP_CLF) |=> (!q.c && !q.z && !q.d));

endmodule

// File: tb/nib_cpu_test.sv
module nib_cpu_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, restart, data_flag_in;
    logic [7:0] mem_addr;
    logic [3:0] mem_rdata, mem_wdata;
    logic       mem_we, halted;

    nib_cpu uut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .data_flag_in(data_flag_in),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .halted(halted)
    );

    logic [3:0] mem [256];
    logic       ld_we, ld_clr;
    logic [7:0] ld_addr;
    logic [3:0] ld_data;

    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 4'h0;
        end else if (ld_we) mem[ld_addr] <= ld_data;
        else if (mem_we)    mem[mem_addr] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr];

    int checks = 0, failures = 0, ptr = 0;

    // fields: op[30:27] cin[26] ac[25:18] imm[17:10] exp_ac[9:2] exp_c[1] exp_z[0]
    localparam int NV = 17;
    localparam logic [30:0] VECS [NV] = '{
        {4'h7, 1'b0, 8'h3C, 8'h15, 8'h51, 1'b0, 1'b0},
        {4'h7, 1'b0, 8'hF0, 8'h10, 8'h00, 1'b1, 1'b1},
        {4'h7, 1'b0, 8'hC8, 8'h4A, 8'h12, 1'b1, 1'b0},
        {4'h7, 1'b1, 8'h01, 8'h01, 8'h02, 1'b0, 1'b0},
        {4'h8, 1'b0, 8'h50, 8'h20, 8'h30, 1'b0, 1'b0},
        {4'h8, 1'b0, 8'h20, 8'h50, 8'hD0, 1'b1, 1'b0},
        {4'h8, 1'b0, 8'h77, 8'h77, 8'h00, 1'b0, 1'b1},
        {4'hA, 1'b0, 8'h40, 8'h41, 8'h40, 1'b1, 1'b0},
        {4'hA, 1'b0, 8'h99, 8'h99, 8'h99, 1'b0, 1'b1},
        {4'h5, 1'b1, 8'hF3, 8'h3C, 8'h30, 1'b1, 1'b0},
        {4'h5, 1'b0, 8'hA5, 8'h5A, 8'h00, 1'b0, 1'b1},
        {4'h6, 1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},
        {4'h6, 1'b0, 8'h81, 8'h18, 8'h99, 1'b0, 1'b0},
        {4'hD, 1'b0, 8'h81, 8'h00, 8'h02, 1'b1, 1'b0},
        {4'hD, 1'b1, 8'h40, 8'h00, 8'h81, 1'b0, 1'b1},
        {4'hE, 1'b0, 8'h01, 8'h00, 8'h00, 1'b1, 1'b0},
        {4'hE, 1'b1, 8'h02, 8'h00, 8'h81, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input int d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a[7:0]; ld_data = d[3:0];
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic emit(input int v);
        poke(ptr, v);
        ptr++;
    endtask

    task automatic emit3(input int op, input int val);
        emit(op); emit(val & 15); emit((val >> 4) & 15);
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0; restart = 1'b0; data_flag_in = 1'b0;
        ld_clr = 1'b1;
        @(negedge clk);
        ld_clr = 1'b0;
        ptr = 0;
    endtask

    task automatic go();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string tag);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (halted) return;
        end
        chk({tag, " halt reached"}, 0, 1);
    endtask

    function automatic int rd16(input int a);
        return {mem[a[7:0] + 8'd1], mem[a[7:0]]};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h7:       return "R4";
            4'h8, 4'hA: return "R5";
            4'h5, 4'h6: return "R6";
            default:    return "R7";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; restart = 1'b0; data_flag_in = 1'b0;
        ld_we = 1'b0; ld_clr = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (3) @(posedge clk);

        // Table walk: R2 operand order, R3 store, R4..R7 results, R8 flag probes
        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            logic [3:0]  op;
            int end_addr, exp_addr;
            v  = VECS[i];
            op = v[30:27];
            begin_prog();
            emit(4'hF);
            if (v[26]) begin emit3(1, 'hF2); emit3(7, 1); end
            emit3(1, 'hF0);
            emit(op);
            if (op != 4'hD && op != 4'hE) begin emit(v[13:10]); emit(v[17:14]); end
            emit3(2, 'hE0);
            emit3('hC, 'h20);
            emit3(9, 'h30);
            emit(0);
            end_addr = ptr;
            ptr = 'h20; emit3(9, 'h40); emit(0);
            poke('hF0, v[21:18]); poke('hF1, v[25:22]);
            poke('hF2, 'hF); poke('hF3, 'hF);
            go();
            wait_halt(tag_of(op));
            chk({tag_of(op), " R2 R3 result"}, rd16('hE0), v[9:2]);
            exp_addr = v[1] ? (v[0] ? end_addr : 'h31) : (v[0] ? 'h24 : 'h41);
            chk({tag_of(op), " R8 flags C/Z via jumps"}, mem_addr, exp_addr);
        end

        // R1: reset state, and AC/flags cleared after a dirty run
        begin_prog();
        emit3(2, 'hE0); emit3(9, 'h20); emit(0);
        ptr = 'h20; emit3('hC, 'h30); emit(0);
        ptr = 'h30; emit3('hB, 'h40); emit(0);
        poke('hE0, 5); poke('hE1, 5);
        go();
        chk("R1 first address", mem_addr, 0);
        chk("R1 halted low", halted, 0);
        wait_halt("R1");
        chk("R1 accumulator zero", rd16('hE0), 0);
        chk("R1 flags clear (all jumps taken)", mem_addr, 'h41);

        // R9 + R8 jump: save-PC after jump
        begin_prog();
        emit3(3, 'h10);
        ptr = 'h10; emit3(4, 'hE4); emit(0);
        go();
        wait_halt("R9");
        chk("R9 saved next address", rd16('hE4), 'h13);
        chk("R8 jump target", mem_addr, 'h14);

        // R3 wrap on store and load
        begin_prog();
        emit3(3, 'h50);
        ptr = 'h50; emit3(1, 'hF0); emit3(2, 'hFF); emit3(1, 'hFF); emit3(2, 'hE0); emit(0);
        poke('hF0, 'hA); poke('hF1, 6);
        go();
        wait_halt("R3");
        chk("R3 store wraps high nibble to 0x00", mem[0], 6);
        chk("R3 store low nibble at 0xFF", mem[8'hFF], 'hA);
        chk("R3 load wraps", rd16('hE0), 'h6A);

        // R10 halt and restart
        begin_prog();
        emit(0); emit3(1, 'hF0); emit3(2, 'hE0); emit(0);
        poke('hF0, 'hA); poke('hF1, 5);
        go();
        wait_halt("R10");
        chk("R10 address after halt", mem_addr, 1);
        repeat (10) @(negedge clk);
        chk("R10 stays halted", halted, 1);
        chk("R10 no progress while halted", rd16('hE0), 0);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R10 leaves halt on restart", halted, 0);
        wait_halt("R10 resumed");
        chk("R10 resumed program stored", rd16('hE0), 'h5A);
        chk("R10 second halt address", mem_addr, 8);

        // R11: short pulse on external flag stays latched
        begin_prog();
        emit3(1, 'hF0); emit3(1, 'hF0); emit3(1, 'hF0); emit3('hB, 'h20); emit(0);
        ptr = 'h20; emit(0);
        go();
        data_flag_in = 1'b1;
        repeat (3) @(negedge clk);
        data_flag_in = 1'b0;
        wait_halt("R11");
        chk("R11 D sticky, jump not taken", mem_addr, 13);

        // R12: clear-flags drops D
        begin_prog();
        emit3(1, 'hF0); emit3(1, 'hF0); emit3(1, 'hF0); emit('hF); emit3('hB, 'h20); emit(0);
        ptr = 'h20; emit(0);
        go();
        data_flag_in = 1'b1;
        repeat (3) @(negedge clk);
        data_flag_in = 1'b0;
        wait_halt("R12");
        chk("R12 D cleared, jump taken", mem_addr, 'h21);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule